// File: doc/BRIEF.md
# PCI Address Window Translation Unit

This block holds the address windows of a PCI host bridge and translates addresses through them. Four outbound windows carry CPU addresses onto the PCI bus. Three inbound windows carry addresses from PCI bus masters into local memory. Software programs the windows through a 32-bit register port that covers a 4 KB region. The same region also holds a gasket timer register that has no function here and is only stored.

Two lookup ports translate addresses. The outbound port serves the CPU side and the inbound port serves the bus-master side. Each port takes a 44-bit address and returns, without any clock delay, three things: a hit flag, the index of the window that matched, and the translated address.

A window matches when it is enabled and the address lies within its range. The range starts at the base register value multiplied by 4096. Its length is a power of two that comes from a 6-bit code in the attribute register. On a hit, the translated address is the translation register value multiplied by 4096, plus the distance of the address above the window start.

The extended-address registers and the attribute bits outside the enable bit and the size code are stored and read back, but they have no effect on translation.

Top module: `pci_xlat_unit`

## Requirements
- R1: After reset, every register reads zero and neither lookup port reports a hit.
- R2: Outbound window n (n = 1 to 4) has its register group at offset 0xC00 + 0x20·n. Within the group, the translation register is at +0x0, the extended translation register at +0x4, the base register at +0x8 and the attribute register at +0x10. Each is a full 32-bit read/write register. Read data appears on `regRdata` one clock edge after the read strobe.
- R3: Inbound windows 0, 1 and 2 have their register groups at 0xDA0, 0xDC0 and 0xDE0. The window index is offset bits [6:5] minus one. Within the group, the translation register is at +0x0, the base register at +0x8, the extended base register at +0xC and the attribute register at +0x10.
- R4: Offset 0xE20 is a 32-bit read/write timer register.
- R5: Any other offset reads back zero, and writes to it change no register. This includes offsets 0x0 and 0x4, unaligned offsets, and offsets that are unused inside a window group.
- R6: Bit 31 of the attribute register enables its window. A window whose bit 31 is clear never hits.
- R7: A window covers the addresses from base·4096 up to, but not including, base·4096 + (2 << attr[5:0]). A code of 11 therefore gives 4 KB.
- R8: On a hit, the translated address is tar·4096 + (addr − base·4096), truncated to 44 bits.
- R9: When several enabled windows match, the lowest index wins. The outbound index output gives the group number 1 to 4. The inbound index output gives 0 to 2.
- R10: On a miss, the hit output is low, the index output is 0, and the translated address equals the input address.
- R11: A register write changes the lookup result from the clock edge that performs the write onward. There is no separate commit step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte offset within the 4 KB region |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| obAddr | input | 44 | Outbound lookup address |
| obHit | output | 1 | Outbound hit |
| obIdx | output | 3 | Outbound matching window number |
| obXlat | output | 44 | Outbound translated address |
| ibAddr | input | 44 | Inbound lookup address |
| ibHit | output | 1 | Inbound hit |
| ibIdx | output | 3 | Inbound matching window index |
| ibXlat | output | 44 | Inbound translated address |

## Verification
Read data is due on the clock edge that follows the read strobe. The bench drives the strobe at a falling edge and samples `regRdata` at the next falling edge.

The lookups are purely combinational. The bench therefore samples them one nanosecond after it changes the address. A register write first shows in the lookup at the falling edge after the rising edge that stores it, and that is where the check of write visibility (R11) is placed.

The bench sweeps every word-aligned offset of the 4 KB register region. It also sweeps the lookup addresses across each window's edges.

// File: rtl/pcixlat_pkg.sv
package pcixlat_pkg;
  localparam int REG_AW    = 12;
  localparam int IDX_W     = 3;
  localparam int PAGE_BITS = 12;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_OUT   = 2'd1,
    SEL_IN    = 2'd2,
    SEL_TIMER = 2'd3
  } regSel_e;

  // Strobe bundle sent from the decoder to the datapath.
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    regSel_e    sel;
    logic [2:0] win;    // zero-based window slot
    logic [1:0] field;  // register slot inside the group
  } regStrobe_t;
endpackage

// File: rtl/pcixlat_ctrl.sv
module pcixlat_ctrl
  import pcixlat_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 3
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [REG_AW-1:0] TIMER_OFS = 12'hE20;
  localparam logic [3:0]        OUT_PAGE  = 4'hC;
  localparam logic [3:0]        IN_PAGE   = 4'hD;

  logic [3:0] page;
  logic [2:0] grp;
  logic [4:0] sub;
  logic [1:0] outFld, inFld;
  logic       outOk, inOk;

  assign page = regAddr[11:8];
  assign grp  = regAddr[7:5];
  assign sub  = regAddr[4:0];

  // Field slots of an outbound group: translation, extended translation, base, attributes.
  always_comb begin
    outOk = 1'b1;
    unique case (sub)
      5'h00:   outFld = 2'd0;
      5'h04:   outFld = 2'd1;
      5'h08:   outFld = 2'd2;
      5'h10:   outFld = 2'd3;
      default: begin outFld = 2'd0; outOk = 1'b0; end
    endcase
  end

  // Field slots of an inbound group: translation, base, extended base, attributes.
  always_comb begin
    inOk = 1'b1;
    unique case (sub)
      5'h00:   inFld = 2'd0;
      5'h08:   inFld = 2'd1;
      5'h0C:   inFld = 2'd2;
      5'h10:   inFld = 2'd3;
      default: begin inFld = 2'd0; inOk = 1'b0; end
    endcase
  end

  always_comb begin
    strb       = '0;
    strb.wrEn  = regWe;
    strb.rdEn  = regRe;
    strb.sel   = SEL_NONE;
    if (page == OUT_PAGE && grp != 3'd0 && int'(grp) <= NUM_OUT && outOk) begin
      strb.sel   = SEL_OUT;
      strb.win   = grp - 3'd1;
      strb.field = outFld;
    end else if (page == IN_PAGE && grp[2] && grp[1:0] != 2'd0 &&
                 int'(grp[1:0]) <= NUM_IN && inOk) begin
      strb.sel   = SEL_IN;
      strb.win   = {1'b0, grp[1:0] - 2'd1};
      strb.field = inFld;
    end else if (regAddr == TIMER_OFS) begin
      strb.sel   = SEL_TIMER;
    end
  end
endmodule

// File: rtl/pcixlat_lookup.sv
module pcixlat_lookup
  import pcixlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_OFS = 0,
  parameter int DW      = 32,
  parameter int AW      = DW + PAGE_BITS
) (
  input  logic [AW-1:0]              addr,
  input  logic [NUM_WIN-1:0]         enMask,
  input  logic [NUM_WIN-1:0][5:0]    sizeCode,
  input  logic [NUM_WIN-1:0][DW-1:0] baseRegs,
  input  logic [NUM_WIN-1:0][DW-1:0] tarRegs,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx,
  output logic [AW-1:0]              xlat
);
  logic [NUM_WIN-1:0] match;
  logic [AW-1:0]      xl [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [AW-1:0] baseFull, tarFull, diff;
    logic [6:0]    shamt;
    assign baseFull = {baseRegs[g], {PAGE_BITS{1'b0}}};
    assign tarFull  = {tarRegs[g], {PAGE_BITS{1'b0}}};
    assign diff     = addr - baseFull;
    assign shamt    = {1'b0, sizeCode[g]} + 7'd1;
    // Inside the window when the offset has no bit at or above log2(size).
    assign match[g] = enMask[g] && (addr >= baseFull) && ((diff >> shamt) == '0);
    assign xl[g]    = tarFull + diff;
  end

  // Walk from the highest slot down so the lowest matching slot is applied last.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    xlat = addr;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit  = 1'b1;
        idx  = IDX_W'(w + IDX_OFS);
        xlat = xl[w];
      end
    end
  end
endmodule

// File: rtl/pcixlat_dp.sv
module pcixlat_dp
  import pcixlat_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 3,
  parameter int DW      = 32,
  parameter int AW      = DW + PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [DW-1:0]    regWdata,
  output logic [DW-1:0]    regRdata,
  input  logic [AW-1:0]    obAddr,
  output logic             obHit,
  output logic [IDX_W-1:0] obIdx,
  output logic [AW-1:0]    obXlat,
  input  logic [AW-1:0]    ibAddr,
  output logic             ibHit,
  output logic [IDX_W-1:0] ibIdx,
  output logic [AW-1:0]    ibXlat
);
  localparam int NFLD = 4;
  // Slot numbers of the fields the translator uses.
  localparam int OB_TAR = 0, OB_BASE = 2, OB_ATTR = 3;
  localparam int IB_TAR = 0, IB_BASE = 1, IB_ATTR = 3;

  logic [DW-1:0] outReg [NUM_OUT][NFLD];
  logic [DW-1:0] inReg  [NUM_IN][NFLD];
  logic [DW-1:0] timerReg;
  logic [DW-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_OUT; w++)
        for (int f = 0; f < NFLD; f++) outReg[w][f] <= '0;
      for (int w = 0; w < NUM_IN; w++)
        for (int f = 0; f < NFLD; f++) inReg[w][f] <= '0;
      timerReg <= '0;
    end else if (strb.wrEn) begin
      for (int w = 0; w < NUM_OUT; w++)
        if (strb.sel == SEL_OUT && strb.win == 3'(w)) outReg[w][strb.field] <= regWdata;
      for (int w = 0; w < NUM_IN; w++)
        if (strb.sel == SEL_IN && strb.win == 3'(w)) inReg[w][strb.field] <= regWdata;
      if (strb.sel == SEL_TIMER) timerReg <= regWdata;
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strb.sel)
      SEL_OUT:
        for (int w = 0; w < NUM_OUT; w++)
          if (strb.win == 3'(w)) rdNext = outReg[w][strb.field];
      SEL_IN:
        for (int w = 0; w < NUM_IN; w++)
          if (strb.win == 3'(w)) rdNext = inReg[w][strb.field];
      SEL_TIMER: rdNext = timerReg;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regRdata <= '0;
    else if (strb.rdEn) regRdata <= rdNext;
  end

  logic [NUM_OUT-1:0]         obEn;
  logic [NUM_OUT-1:0][5:0]    obCode;
  logic [NUM_OUT-1:0][DW-1:0] obBase, obTar;
  logic [NUM_IN-1:0]          ibEn;
  logic [NUM_IN-1:0][5:0]     ibCode;
  logic [NUM_IN-1:0][DW-1:0]  ibBase, ibTar;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_obw
    assign obEn[g]   = outReg[g][OB_ATTR][DW-1];
    assign obCode[g] = outReg[g][OB_ATTR][5:0];
    assign obBase[g] = outReg[g][OB_BASE];
    assign obTar[g]  = outReg[g][OB_TAR];
  end
  for (genvar g = 0; g < NUM_IN; g++) begin : g_ibw
    assign ibEn[g]   = inReg[g][IB_ATTR][DW-1];
    assign ibCode[g] = inReg[g][IB_ATTR][5:0];
    assign ibBase[g] = inReg[g][IB_BASE];
    assign ibTar[g]  = inReg[g][IB_TAR];
  end

  pcixlat_lookup #(.NUM_WIN(NUM_OUT), .IDX_OFS(1), .DW(DW), .AW(AW)) u_obLook (
    .addr(obAddr), .enMask(obEn), .sizeCode(obCode), .baseRegs(obBase), .tarRegs(obTar),
    .hit(obHit), .idx(obIdx), .xlat(obXlat)
  );

  pcixlat_lookup #(.NUM_WIN(NUM_IN), .IDX_OFS(0), .DW(DW), .AW(AW)) u_ibLook (
    .addr(ibAddr), .enMask(ibEn), .sizeCode(ibCode), .baseRegs(ibBase), .tarRegs(ibTar),
    .hit(ibHit), .idx(ibIdx), .xlat(ibXlat)
  );

  assert_ob_miss_passthru_R10: assert property (@(posedge clk) disable iff (!rstN)
    !obHit |-> (obXlat == obAddr && obIdx == '0));
  assert_ib_miss_passthru_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ibHit |-> (ibXlat == ibAddr && ibIdx == '0));
  assert_ob_hit_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    obHit |-> (obIdx >= 3'd1 && int'(obIdx) <= NUM_OUT &&
               (obEn & (NUM_OUT'(1) << (obIdx - 3'd1))) != '0));
  assert_ib_hit_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    ibHit |-> (int'(ibIdx) < NUM_IN && (ibEn & (NUM_IN'(1) << ibIdx)) != '0));
  assert_unmapped_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.sel == SEL_NONE) |=> regRdata == '0);
endmodule

// File: rtl/pci_xlat_unit.sv
module pci_xlat_unit
  import pcixlat_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_IN  = 3,
  parameter int DW      = 32,
  parameter int AW      = DW + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [AW-1:0]     obAddr,
  output logic              obHit,
  output logic [IDX_W-1:0]  obIdx,
  output logic [AW-1:0]     obXlat,
  input  logic [AW-1:0]     ibAddr,
  output logic              ibHit,
  output logic [IDX_W-1:0]  ibIdx,
  output logic [AW-1:0]     ibXlat
);
  regStrobe_t strb;

  pcixlat_ctrl #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_ctrl (
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .strb(strb)
  );

  pcixlat_dp #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .regRdata(regRdata),
    .obAddr(obAddr), .obHit(obHit), .obIdx(obIdx), .obXlat(obXlat),
    .ibAddr(ibAddr), .ibHit(ibHit), .ibIdx(ibIdx), .ibXlat(ibXlat)
  );
endmodule

// File: tb/pci_xlat_unit_bench.sv
`timescale 1ns/1ps
module pci_xlat_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [43:0] obAddr = '0, ibAddr = '0;
  logic        obHit, ibHit;
  logic [2:0]  obIdx, ibIdx;
  logic [43:0] obXlat, ibXlat;

  int nChecks = 0;
  int nFails  = 0;

  // Bench copy of register contents.
  // Outbound group n = 1..4, fields: 0 tar, 1 ext, 2 base, 3 attr.
  // Inbound group k = 0..2, fields: 0 tar, 1 base, 2 ext, 3 attr.
  logic [31:0] outM [5][4];
  logic [31:0] inM  [3][4];
  logic [31:0] timerM;
  int outOfs [4] = '{0, 4, 8, 16};
  int inOfs  [4] = '{0, 8, 12, 16};

  always #2 clk = ~clk;

  pci_xlat_unit u_pci_xlat_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .obAddr(obAddr), .obHit(obHit), .obIdx(obIdx), .obXlat(obXlat),
    .ibAddr(ibAddr), .ibHit(ibHit), .ibIdx(ibIdx), .ibXlat(ibXlat)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wrRaw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic wrOut(input int n, input int f, input logic [31:0] d);
    wrRaw(12'(12'hC00 + 32 * n + outOfs[f]), d);
    outM[n][f] = d;
  endtask

  task automatic wrIn(input int k, input int f, input logic [31:0] d);
    wrRaw(12'(12'hDA0 + 32 * k + inOfs[f]), d);
    inM[k][f] = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    @(negedge clk);
    regRe = 1'b0;
    d = regRdata;
  endtask

  function automatic void expRead(input logic [11:0] a, output logic [31:0] v, output string tag);
    v = '0; tag = "R5";
    for (int n = 1; n <= 4; n++)
      for (int f = 0; f < 4; f++)
        if (int'(a) == 'hC00 + 32 * n + outOfs[f]) begin v = outM[n][f]; tag = "R2"; end
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 4; f++)
        if (int'(a) == 'hDA0 + 32 * k + inOfs[f]) begin v = inM[k][f]; tag = "R3"; end
    if (a == 12'hE20) begin v = timerM; tag = "R4"; end
  endfunction

  task automatic sweepRegs(input string phase);
    logic [31:0] got, exp;
    string tag;
    for (int a = 0; a < 4096; a += 4) begin
      rd(12'(a), got);
      expRead(12'(a), exp, tag);
      check(got === exp, tag, $sformatf("%s read @%03h", phase, a), 64'(got), 64'(exp));
    end
  endtask

  // Bench model of a lookup, in 128-bit arithmetic.
  function automatic void expLook(input bit isOut, input logic [43:0] a,
                                  output bit h, output logic [2:0] ix, output logic [43:0] x);
    logic [127:0] base, sz, a128;
    h = 1'b0; ix = '0; x = a; a128 = 128'(a);
    if (isOut) begin
      for (int n = 1; n <= 4; n++) begin
        base = 128'(outM[n][2]) << 12;
        sz   = 128'd2 << outM[n][3][5:0];
        if (!h && outM[n][3][31] && a128 >= base && a128 < base + sz) begin
          h = 1'b1; ix = 3'(n); x = 44'((128'(outM[n][0]) << 12) + a128 - base);
        end
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        base = 128'(inM[k][1]) << 12;
        sz   = 128'd2 << inM[k][3][5:0];
        if (!h && inM[k][3][31] && a128 >= base && a128 < base + sz) begin
          h = 1'b1; ix = 3'(k); x = 44'((128'(inM[k][0]) << 12) + a128 - base);
        end
      end
    end
  endfunction

  task automatic lookOb(input logic [43:0] a, input string tag);
    bit h; logic [2:0] ix; logic [43:0] x;
    obAddr = a; #1;
    expLook(1'b1, a, h, ix, x);
    check(obHit === h && obIdx === ix && obXlat === x, tag,
          $sformatf("outbound @%h {hit,idx,xlat}", a),
          {16'(obHit), 4'(obIdx), obXlat}, {16'(h), 4'(ix), x});
  endtask

  task automatic lookIb(input logic [43:0] a, input string tag);
    bit h; logic [2:0] ix; logic [43:0] x;
    ibAddr = a; #1;
    expLook(1'b0, a, h, ix, x);
    check(ibHit === h && ibIdx === ix && ibXlat === x, tag,
          $sformatf("inbound @%h {hit,idx,xlat}", a),
          {16'(ibHit), 4'(ibIdx), ibXlat}, {16'(h), 4'(ix), x});
  endtask

  task automatic edgesOb(input int n);
    logic [43:0] b, s;
    b = 44'(outM[n][2]) << 12;
    s = 44'd2 << outM[n][3][5:0];
    lookOb(b - 44'd1, "R7"); lookOb(b, "R7"); lookOb(b + s - 44'd1, "R7"); lookOb(b + s, "R7");
  endtask

  task automatic edgesIb(input int k);
    logic [43:0] b, s;
    b = 44'(inM[k][1]) << 12;
    s = (inM[k][3][5:0] >= 6'd43) ? 44'd0 : (44'd2 << inM[k][3][5:0]);
    lookIb(b - 44'd1, "R7"); lookIb(b, "R7");
    if (s != 0) begin lookIb(b + s - 44'd1, "R7"); lookIb(b + s, "R7"); end
  endtask

  initial begin
    for (int n = 0; n < 5; n++) for (int f = 0; f < 4; f++) outM[n][f] = '0;
    for (int k = 0; k < 3; k++) for (int f = 0; f < 4; f++) inM[k][f] = '0;
    timerM = '0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of all registers and both lookups.
    sweepRegs("R1 reset");
    lookOb(44'h0, "R1"); lookOb(44'h12345, "R1");
    lookIb(44'h0, "R1"); lookIb(44'hFFF_FFFF_FFFF, "R1");

    // R2, R3, R4: fill every register with a distinct pattern.
    for (int n = 1; n <= 4; n++)
      for (int f = 0; f < 4; f++) wrOut(n, f, 32'h1357_0000 + 32'(n * 16 + f) + 32'(f << 24));
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 4; f++) wrIn(k, f, 32'h2468_0000 + 32'(k * 16 + f) + 32'(f << 20));
    wrRaw(12'hE20, 32'hCAFE_F00D); timerM = 32'hCAFE_F00D;

    // R5: writes to unassigned offsets must not land anywhere.
    wrRaw(12'h000, 32'hFFFF_FFFF); wrRaw(12'h004, 32'hFFFF_FFFF);
    wrRaw(12'hC00, 32'hFFFF_FFFF); wrRaw(12'hC2C, 32'hFFFF_FFFF);
    wrRaw(12'hC34, 32'hFFFF_FFFF); wrRaw(12'hCA0, 32'hFFFF_FFFF);
    wrRaw(12'hD80, 32'hFFFF_FFFF); wrRaw(12'hDA4, 32'hFFFF_FFFF);
    wrRaw(12'hDB4, 32'hFFFF_FFFF); wrRaw(12'hC21, 32'hFFFF_FFFF);
    wrRaw(12'hE24, 32'hFFFF_FFFF); wrRaw(12'hFFC, 32'hFFFF_FFFF);
    sweepRegs("filled");

    // Window setup for translation sweeps.
    for (int n = 1; n <= 4; n++) wrOut(n, 3, 32'h0);
    for (int k = 0; k < 3; k++) wrIn(k, 3, 32'h0);
    wrOut(1, 2, 32'h10);       wrOut(1, 0, 32'h80000);     wrOut(1, 3, 32'h8000_000F);
    wrOut(2, 2, 32'h1C);       wrOut(2, 0, 32'h900);       wrOut(2, 3, 32'h8000_000E);
    wrOut(3, 2, 32'h40);       wrOut(3, 0, 32'h5);         wrOut(3, 3, 32'h7FFF_FF14);
    wrOut(4, 2, 32'h30);       wrOut(4, 0, 32'hFFFF_FFFF); wrOut(4, 3, 32'h8000_000B);
    wrIn(0, 1, 32'h200);       wrIn(0, 0, 32'h7);          wrIn(0, 3, 32'h8000_000C);
    wrIn(1, 1, 32'h10_0000);   wrIn(1, 0, 32'h20);         wrIn(1, 3, 32'h8000_003F);
    wrIn(2, 1, 32'h0);         wrIn(2, 0, 32'h3);          wrIn(2, 3, 32'h8000_000B);

    // R7, R8, R9, R10, R6: outbound sweep across all windows (R6: group 3 disabled).
    for (int a = 0; a < 'h50000; a += 'h400) lookOb(44'(a), "R8");
    for (int n = 1; n <= 4; n++) edgesOb(n);
    lookOb(44'h1C000, "R9"); lookOb(44'h1FFFF, "R9"); lookOb(44'h20000, "R9");
    lookOb(44'h40010, "R6"); lookOb(44'hFFF_FFFF_FFFF, "R10");

    // Inbound sweep, including the window that covers the top of the space.
    for (int a = 0; a < 'h300000; a += 'h2000) lookIb(44'(a), "R8");
    for (int k = 0; k < 3; k++) edgesIb(k);
    lookIb(44'hFFF_FFFF_FFFF, "R7"); lookIb(44'h1_0000_0000, "R8");
    lookIb(44'h0FFF, "R9"); lookIb(44'h1000, "R10");

    // R11: enabling a window changes the next lookup with no commit step.
    obAddr = 44'h40010;
    wrOut(3, 3, 32'h8000_0014);
    #1;
    check(obHit === 1'b1 && obIdx === 3'd3 && obXlat === 44'h5010, "R11",
          "outbound after enabling group 3", {16'(obHit), 4'(obIdx), obXlat},
          {16'h1, 4'h3, 44'h5010});
    // R11, R9: disabling group 1 exposes group 2 in the overlap.
    obAddr = 44'h1C000;
    wrOut(1, 3, 32'h0);
    #1;
    check(obHit === 1'b1 && obIdx === 3'd2 && obXlat === 44'h900000, "R11",
          "outbound after disabling group 1", {16'(obHit), 4'(obIdx), obXlat},
          {16'h1, 4'h2, 44'h900000});
    // R11: moving an inbound base moves the hit on the next lookup.
    ibAddr = 44'h5000;
    wrIn(2, 1, 32'h5);
    #1;
    check(ibHit === 1'b1 && ibIdx === 3'd2 && ibXlat === 44'h3000, "R11",
          "inbound after moving window 2", {16'(ibHit), 4'(ibIdx), ibXlat},
          {16'h1, 4'h2, 44'h3000});
    lookOb(44'h1C000, "R9"); lookIb(44'h5FFF, "R7");

    summary();
    $finish;
  end
endmodule